// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback divide value, a 3-bit output divider code and a 2-bit test-select code. Software or board straps can load the settings in two ways. The first is a parallel bus that is transparent while its active-low strobe is low and is captured when that strobe rises. The second is a three-wire serial port with data, clock and load lines. A 14-bit frame is shifted in, moved into the settings when the load line rises, and frozen when it falls. While the load line is held high, each serial clock updates the settings directly.

All strobes and pins are asynchronous to the system clock. They are brought in through two-flop synchronizers, and edges are found by comparing each synchronized sample with the one before it. The test-select code drives a diagnostic output multiplexer. That output is held low whenever the parallel strobe is low. A master reset input is passed on to the dividers and leaves the stored settings alone.

Top module: `synth_cfg_loader`

## Requirements
- R1: During system reset (rstN low) the test code clears to 00, and the feedback and output divider values take the levels on mPar and nPar.
- R2: While pLoadN is low, mVal and nVal follow mPar and nPar.
- R3: A rising edge of pLoadN captures mPar and nPar. Later pin changes have no effect while pLoadN stays high.
- R4: With pLoadN high and sLoad low, each rising sClk shifts sData into a 14-bit shift register at bit 0. A frame is sent test bit 1 first, then test bit 0, nVal bits 2 down to 0, and mVal bits 8 down to 0. Shifting alone leaves the outputs unchanged.
- R5: A rising sLoad copies the shift register to {tVal, nVal, mVal}, with tVal in bits 13:12, nVal in 11:9 and mVal in 8:0. After sLoad falls, the values stay fixed while further bits are shifted in.
- R6: While sLoad stays high, each rising sClk shifts sData in and copies the new shift register value to {tVal, nVal, mVal}.
- R7: testOut is chosen by tVal: 00 gives 0, 01 gives synchronized sData, 10 gives fbDivIn and 11 gives outClkIn.
- R8: testOut is 0 whenever synchronized pLoadN is low.
- R9: masterRst reaches divRst after two clock edges and does not change mVal, nVal or tVal.
- R10: If a rising sLoad and a rising sClk appear in the same synchronized sample, the transfer uses the shift register contents from before that sample, and that clock edge is dropped.
- R11: Serial clock and load edges seen while pLoadN is low leave the shift register unchanged.
- R12: A change on pLoadN, mPar, nPar, sLoad or sClk reaches mVal, nVal and tVal on the third rising clk edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low system reset |
| pLoadN | input | 1 | Active-low parallel load strobe |
| mPar | input | 9 | Parallel feedback divide value |
| nPar | input | 3 | Parallel output divider code |
| sClk | input | 1 | Serial port clock |
| sData | input | 1 | Serial port data |
| sLoad | input | 1 | Serial port load strobe |
| masterRst | input | 1 | Divider reset request |
| fbDivIn | input | 1 | Feedback divider output, for test observation |
| outClkIn | input | 1 | Output clock, for test observation |
| mVal | output | 9 | Active feedback divide value |
| nVal | output | 3 | Active output divider code |
| tVal | output | 2 | Active test-select code |
| testOut | output | 1 | Diagnostic output |
| divRst | output | 1 | Synchronized divider reset |

## Verification
The risky coincidence is a serial clock rise that lands in the same synchronized sample as a load-strobe rise. Two reasonable designs disagree here: one treats it as a transfer, the other as a pass-through update. The bench raises both lines at the same instant, after shifting in a frame that differs from the current settings. It then checks that the frame from before the edge was transferred. A second load edge with no clocks must reproduce that same frame, which shows the coincident clock did not shift the register. A cycle-accurate behavioural model also runs every cycle and covers the meeting of a parallel-strobe rise with pending serial edges.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // width of the test-select code; the diagnostic mux has 2**TEST_W inputs
  localparam int TEST_W = 2;

  // one-cycle update commands from control to datapath
  typedef struct packed {
    logic parLd;   // load divider values from synchronized parallel pins
    logic shift;   // shift one serial bit, settings untouched
    logic xfer;    // copy shift register into the settings
    logic pass;    // shift one bit and copy the result into the settings
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stage;

  // during reset every stage tracks the pin so no false edge follows release
  always_ff @(posedge clk) begin
    if (!rstN) stage <= {STAGES{din}};
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pLoadN,
  input  logic           sLoad,
  input  logic           sClk,
  input  logic           sData,
  input  logic           masterRst,
  input  logic [M_W-1:0] mPar,
  input  logic [N_W-1:0] nPar,
  output cfgStrobe_t     stb,
  output logic [M_W-1:0] mSync,
  output logic [N_W-1:0] nSync,
  output logic           sDataSync,
  output logic           parMode,
  output logic           divRst
);

  localparam int CTL_W = 5;
  localparam int PAR_W = M_W + N_W;

  logic [CTL_W-1:0] ctlSync;
  logic [PAR_W-1:0] parSync;
  logic pSync, lSync, cSync;
  logic pPrev, lPrev, cPrev;
  logic lRise, cRise, serialArmed;

  cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctlSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({pLoadN, sLoad, sClk, sData, masterRst}),
    .dout (ctlSync)
  );

  cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES)) u_parSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({mPar, nPar}),
    .dout (parSync)
  );

  assign {pSync, lSync, cSync, sDataSync, divRst} = ctlSync;
  assign mSync = parSync[PAR_W-1:N_W];
  assign nSync = parSync[N_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pPrev <= pLoadN;
      lPrev <= sLoad;
      cPrev <= sClk;
    end else begin
      pPrev <= pSync;
      lPrev <= lSync;
      cPrev <= cSync;
    end
  end

  assign parMode     = !pSync;
  assign lRise       = lSync && !lPrev;
  assign cRise       = cSync && !cPrev;
  // serial events count only once the parallel strobe has been high for a sample
  assign serialArmed = pSync && pPrev;

  always_comb begin
    stb       = '0;
    stb.parLd = !serialArmed;
    if (serialArmed) begin
      stb.xfer  = lRise;
      stb.shift = cRise && !lRise && !lSync;
      stb.pass  = cRise && !lRise && lSync;
    end
  end

endmodule

// File: rtl/cfg_dp.sv
module cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [M_W-1:0]    mSync,
  input  logic [N_W-1:0]    nSync,
  input  logic              sDataSync,
  input  logic              parMode,
  input  logic [M_W-1:0]    mPar,
  input  logic [N_W-1:0]    nPar,
  input  logic              fbDivIn,
  input  logic              outClkIn,
  output logic [M_W-1:0]    mVal,
  output logic [N_W-1:0]    nVal,
  output logic [TEST_W-1:0] tVal,
  output logic [TEST_W+N_W+M_W-1:0] shiftQ,
  output logic              testOut
);

  localparam int FRAME_W = TEST_W + N_W + M_W;
  localparam int SRC_N   = 2 ** TEST_W;

  logic [FRAME_W-1:0] shiftReg, nextShift;
  logic [M_W-1:0]     mReg;
  logic [N_W-1:0]     nReg;
  logic [TEST_W-1:0]  tReg;
  logic [SRC_N-1:0]   testSrc;

  assign nextShift = {shiftReg[FRAME_W-2:0], sDataSync};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tReg     <= '0;
      mReg     <= mPar;
      nReg     <= nPar;
      shiftReg <= '0;
    end else begin
      if (stb.parLd) begin
        mReg <= mSync;
        nReg <= nSync;
      end
      if (stb.xfer)  {tReg, nReg, mReg} <= shiftReg;
      if (stb.shift) shiftReg <= nextShift;
      if (stb.pass) begin
        shiftReg           <= nextShift;
        {tReg, nReg, mReg} <= nextShift;
      end
    end
  end

  // diagnostic sources indexed by the test code
  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    if (g == 0)      assign testSrc[g] = 1'b0;
    else if (g == 1) assign testSrc[g] = sDataSync;
    else if (g == 2) assign testSrc[g] = fbDivIn;
    else             assign testSrc[g] = outClkIn;
  end

  assign testOut = parMode ? 1'b0 : testSrc[tReg];
  assign mVal    = mReg;
  assign nVal    = nReg;
  assign tVal    = tReg;
  assign shiftQ  = shiftReg;

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pLoadN,
  input  logic [M_W-1:0]    mPar,
  input  logic [N_W-1:0]    nPar,
  input  logic              sClk,
  input  logic              sData,
  input  logic              sLoad,
  input  logic              masterRst,
  input  logic              fbDivIn,
  input  logic              outClkIn,
  output logic [M_W-1:0]    mVal,
  output logic [N_W-1:0]    nVal,
  output logic [TEST_W-1:0] tVal,
  output logic              testOut,
  output logic              divRst
);

  localparam int FRAME_W = TEST_W + N_W + M_W;

  cfgStrobe_t         stb;
  logic [M_W-1:0]     mSync;
  logic [N_W-1:0]     nSync;
  logic               sDataSync;
  logic               parMode;
  logic [FRAME_W-1:0] shiftQ;

  cfg_ctrl #(.M_W(M_W), .N_W(N_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pLoadN    (pLoadN),
    .sLoad     (sLoad),
    .sClk      (sClk),
    .sData     (sData),
    .masterRst (masterRst),
    .mPar      (mPar),
    .nPar      (nPar),
    .stb       (stb),
    .mSync     (mSync),
    .nSync     (nSync),
    .sDataSync (sDataSync),
    .parMode   (parMode),
    .divRst    (divRst)
  );

  cfg_dp #(.M_W(M_W), .N_W(N_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .mSync     (mSync),
    .nSync     (nSync),
    .sDataSync (sDataSync),
    .parMode   (parMode),
    .mPar      (mPar),
    .nPar      (nPar),
    .fbDivIn   (fbDivIn),
    .outClkIn  (outClkIn),
    .mVal      (mVal),
    .nVal      (nVal),
    .tVal      (tVal),
    .shiftQ    (shiftQ),
    .testOut   (testOut)
  );

endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
  import synth_cfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input cfgStrobe_t        stb,
  input logic [M_W-1:0]    mSync,
  input logic              sDataSync,
  input logic              parMode,
  input logic [TEST_W+N_W+M_W-1:0] shiftQ,
  input logic [M_W-1:0]    mVal,
  input logic [N_W-1:0]    nVal,
  input logic [TEST_W-1:0] tVal,
  input logic              testOut
);

  localparam int FRAME_W = TEST_W + N_W + M_W;

  // counts cycles since reset so no check reaches back into the reset window
  logic [1:0] upCnt;
  logic       armed;
  always_ff @(posedge clk) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end
  assign armed = (upCnt == 2'd3);

  p_test_low_par_r8: assert property (@(posedge clk) disable iff (!rstN)
    parMode |-> !testOut);

  p_par_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.parLd)) |-> (mVal == $past(mSync)));

  p_xfer_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.xfer)) |-> ({tVal, nVal, mVal} == $past(shiftQ)));

  p_xfer_no_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.xfer)) |-> $stable(shiftQ));

  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.shift)) |->
      (shiftQ == {$past(shiftQ[FRAME_W-2:0]), $past(sDataSync)}));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.pass)) |-> ({tVal, nVal, mVal} == shiftQ));

  p_test_code_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$stable(tVal)) |-> $past(stb.xfer || stb.pass));

  p_div_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$stable({mVal, nVal})) |-> $past(stb.parLd || stb.xfer || stb.pass));

endmodule

bind synth_cfg_loader synth_cfg_checker #(.M_W(M_W), .N_W(N_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stb       (stb),
  .mSync     (mSync),
  .sDataSync (sDataSync),
  .parMode   (parMode),
  .shiftQ    (shiftQ),
  .mVal      (mVal),
  .nVal      (nVal),
  .tVal      (tVal),
  .testOut   (testOut)
);

// File: tb/sim_synth_cfg_loader.sv
`timescale 1ns/100ps
module sim_synth_cfg_loader;

  logic clk = 1'b0;
  logic rstN, pLoadN, sClk, sData, sLoad, masterRst, fbDivIn, outClkIn;
  logic [8:0] mPar;
  logic [2:0] nPar;
  logic [8:0] mVal;
  logic [2:0] nVal;
  logic [1:0] tVal;
  logic testOut, divRst;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  synth_cfg_loader u0 (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN), .mPar(mPar), .nPar(nPar),
    .sClk(sClk), .sData(sData), .sLoad(sLoad), .masterRst(masterRst),
    .fbDivIn(fbDivIn), .outClkIn(outClkIn), .mVal(mVal), .nVal(nVal),
    .tVal(tVal), .testOut(testOut), .divRst(divRst)
  );

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic p; logic l; logic c; logic d; logic mr;
    logic [8:0] m; logic [2:0] n;
  } rawT;

  rawT hist[$];
  rawT rNow, cur, prv;
  logic [1:0]  refT;
  logic [2:0]  refN;
  logic [8:0]  refM;
  logic [13:0] refSh;

  always @(posedge clk) begin
    rNow = '{p:pLoadN, l:sLoad, c:sClk, d:sData, mr:masterRst, m:mPar, n:nPar};
    if (!rstN) begin
      hist  = '{rNow, rNow, rNow, rNow};
      refT  = 2'b00;
      refM  = mPar;
      refN  = nPar;
      refSh = '0;
    end else begin
      hist.push_back(rNow);
      cur = hist[hist.size()-3];   // sample seen through two flops
      prv = hist[hist.size()-4];   // the sample before it
      if (!cur.p || !prv.p) begin
        refM = cur.m;
        refN = cur.n;
      end else if (cur.l && !prv.l) begin
        {refT, refN, refM} = refSh;
      end else if (cur.c && !prv.c) begin
        refSh = {refSh[12:0], cur.d};
        if (cur.l) {refT, refN, refM} = refSh;
      end
      while (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic refTest();
    rawT s = hist[hist.size()-2];
    if (!s.p) return 1'b0;
    case (refT)
      2'b00:   return 1'b0;
      2'b01:   return s.d;
      2'b10:   return fbDivIn;
      default: return outClkIn;
    endcase
  endfunction

  always begin
    @(posedge clk);
    #1;
    if (rstN === 1'b1 && !finished) begin
      testCnt++;
      if ({tVal, nVal, mVal} !== {refT, refN, refM}) begin
        failCnt++;
        $display("FAIL R2/R5/R6 model cfg act=%h exp=%h", {tVal, nVal, mVal}, {refT, refN, refM});
      end
      testCnt++;
      if (testOut !== refTest()) begin
        failCnt++;
        $display("FAIL R7/R8 model testOut act=%0b exp=%0b", testOut, refTest());
      end
      testCnt++;
      if (divRst !== hist[hist.size()-2].mr) begin
        failCnt++;
        $display("FAIL R9 model divRst act=%0b exp=%0b", divRst, hist[hist.size()-2].mr);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    sData = b;
    waitc(4);
    sClk = 1'b1;
    waitc(4);
    sClk = 1'b0;
    waitc(4);
  endtask

  task automatic sendFrame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) sendBit(f[i]);
  endtask

  function automatic logic [31:0] cfgNow();
    return {18'd0, tVal, nVal, mVal};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog expired");
    finish();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [13:0] f1, f2, f3, f4, f5, expCfg;
    rstN = 0; pLoadN = 0; sClk = 0; sData = 0; sLoad = 0;
    masterRst = 0; fbDivIn = 0; outClkIn = 0;
    mPar = 9'd200; nPar = 3'd5;
    waitc(5);
    rstN = 1;
    waitc(1);
    chk("R1 reset cfg", cfgNow(), {18'd0, 2'b00, 3'd5, 9'd200});
    chk("R8 reset testOut", testOut, 0);

    mPar = 9'd123; nPar = 3'd2;
    waitc(4);
    chk("R2 transparent", cfgNow(), {18'd0, 2'b00, 3'd2, 9'd123});

    mPar = 9'd77;
    waitc(2);
    chk("R12 not before third edge", mVal, 9'd123);
    waitc(1);
    chk("R12 on third edge", mVal, 9'd77);

    pLoadN = 1;
    waitc(4);
    mPar = 9'd300; nPar = 3'd7;
    waitc(4);
    chk("R3 captured", cfgNow(), {18'd0, 2'b00, 3'd2, 9'd77});

    f1 = {2'b01, 3'b110, 9'd345};
    sendFrame(f1);
    chk("R4 shift leaves cfg", cfgNow(), {18'd0, 2'b00, 3'd2, 9'd77});
    sLoad = 1;
    waitc(4);
    chk("R5 transfer", cfgNow(), {18'd0, f1});
    sData = 1; waitc(3);
    chk("R7 code01 high", testOut, 1);
    sData = 0; waitc(3);
    chk("R7 code01 low", testOut, 0);

    sLoad = 0;
    waitc(4);
    sendBit(1); sendBit(1); sendBit(1);
    chk("R5 latched after fall", cfgNow(), {18'd0, f1});
    sLoad = 1;
    waitc(4);
    expCfg = {f1[10:0], 3'b111};
    chk("R5 second transfer", cfgNow(), {18'd0, expCfg});
    sendBit(0);
    expCfg = {expCfg[12:0], 1'b0};
    chk("R6 pass-through", cfgNow(), {18'd0, expCfg});

    sLoad = 0; waitc(4);
    f2 = {2'b10, 3'b001, 9'd100};
    sendFrame(f2);
    sLoad = 1; waitc(4);
    fbDivIn = 1; waitc(1);
    chk("R7 code10 high", testOut, 1);
    fbDivIn = 0; waitc(1);
    chk("R7 code10 low", testOut, 0);

    sLoad = 0; waitc(4);
    f3 = {2'b11, 3'b011, 9'd250};
    sendFrame(f3);
    sLoad = 1; waitc(4);
    outClkIn = 1; waitc(1);
    chk("R7 code11", testOut, 1);

    pLoadN = 0; waitc(4);
    chk("R8 parallel forces low", testOut, 0);
    chk("R2 pins follow", mVal, 9'd300);

    sLoad = 0; waitc(4);
    for (int k = 0; k < 14; k++) sendBit(1);
    pLoadN = 1; waitc(4);
    chk("R3 capture after parallel", mVal, 9'd300);
    sLoad = 1; waitc(4);
    chk("R11 shift untouched in parallel", cfgNow(), {18'd0, f3});

    masterRst = 1; waitc(4);
    chk("R9 divRst set", divRst, 1);
    chk("R9 cfg kept", cfgNow(), {18'd0, f3});
    masterRst = 0; waitc(4);
    chk("R9 divRst clear", divRst, 0);

    sLoad = 0; outClkIn = 0; waitc(4);
    f4 = {2'b01, 3'b011, 9'h0AA};
    sendFrame(f4);
    chk("R4 frame pending", cfgNow(), {18'd0, f3});
    sData = 1; waitc(4);
    sClk = 1; sLoad = 1;
    waitc(4);
    chk("R10 coincident transfer", cfgNow(), {18'd0, f4});
    sClk = 0; sLoad = 0; waitc(4);
    sLoad = 1; waitc(4);
    chk("R10 clock dropped", cfgNow(), {18'd0, f4});

    sLoad = 0; waitc(4);
    f5 = {2'b00, 3'b000, 9'd150};
    sendFrame(f5);
    sLoad = 1; waitc(4);
    sData = 1; waitc(3);
    chk("R7 code00 low", testOut, 0);
    chk("R5 final frame", cfgNow(), {18'd0, f5});

    waitc(4);
    finish();
  end

endmodule